// File: doc/BRIEF.md
# MSI Snooping Cache Coherence Controller

This block keeps a small direct-mapped write-back cache coherent with its peers on an atomic shared bus. Each line holds one data word, a tag and one of three coherence states: Invalid, Shared or Modified. Processor reads and writes are answered from the local line when the state allows it. Otherwise the controller requests the bus, fetches the line for reading or for ownership, and then completes the request. A write to a Shared line needs exclusive ownership. No separate upgrade command exists, so that write issues a full read-for-ownership.

The controller also watches bus transactions issued by other caches. A line it holds Modified is flushed when another cache reads it or takes ownership of it. A Shared line is dropped when another cache takes ownership. A separate eviction request removes a line: clean lines go silently and dirty lines are written back first. A processor miss whose index holds a dirty line for another address performs the same write-back on its own before the fetch. The bus is atomic and a bus arbiter outside the block never grants this cache in a cycle where a snoop is presented.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, `cpu_ready`, `evict_ack`, `bus_req` and `snp_flush` are low, and the first access to any address completes as a miss.
- R2: A read that misses requests the bus with command 1 (read) at the requested address. After the grant the line is installed Shared, even if no other cache has a copy. The request completes with `cpu_hit` low and returns the word supplied on `bus_rdata` during the grant.
- R3: A write to a line that is Invalid or Shared requests the bus with command 2 (read for ownership). The line becomes Modified, and the write completes with `cpu_hit` low and stores `cpu_wdata`.
- R4: A read to a Shared or Modified line and a write to a Modified line complete in the cycle they are presented, with `cpu_hit` high and no bus request.
- R5: A snooped command 1 that matches a Modified line raises `snp_flush` in the following cycle with the line's data on `snp_flush_data`, and leaves the line Shared.
- R6: A snooped command 2 that matches a Modified line raises `snp_flush` in the following cycle with the line's data and leaves it Invalid. On a Shared line it leaves it Invalid with no flush. A snoop to an Invalid line or to a different tag has no effect.
- R7: An eviction of a Shared or Invalid line is acknowledged in the cycle it is presented, and the line is then Invalid. An eviction of a Modified line first issues bus command 3 (write-back) carrying the line's address and data, then leaves the line Invalid and is acknowledged.
- R8: A miss whose index holds a Modified line for another tag first writes that line back with command 3, then issues its own fetch.
- R9: In a cycle with `snp_valid` high, no processor request or eviction completes and `bus_req` is low.
- R10: A request that needs the bus holds `cpu_ready` low until its transaction is granted. It completes in the cycle after the grant, so a miss with no victim completes two cycles plus the arbitration wait after it is first presented.
- R11: If a snoop removes the Modified state of a victim while its write-back is still waiting for the bus, the write-back is dropped and the fetch goes ahead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request present, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address; low IDX_W bits select the line, the rest form the tag |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_hit | output | 1 | With `cpu_ready`: 1 = served with no bus transaction |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_ready` on a read |
| evict_req | input | 1 | Eviction request, held until `evict_ack` |
| evict_idx | input | IDX_W | Line to evict |
| evict_ack | output | 1 | Eviction completes this cycle |
| bus_req | output | 1 | Bus transaction requested |
| bus_cmd | output | 2 | 0 none, 1 read, 2 read for ownership, 3 write-back |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Write-back data |
| bus_gnt | input | 1 | Transaction performed in this cycle |
| bus_rdata | input | DATA_W | Fill data, valid with `bus_gnt` |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding as `bus_cmd` |
| snp_addr | input | ADDR_W | Snooped address |
| snp_flush | output | 1 | Flush response, one cycle after the snoop |
| snp_flush_data | output | DATA_W | Flushed line data |

## Verification
Hits, silent evictions and snoop priority show in the same cycle as the stimulus, because `cpu_ready`, `cpu_hit` and `evict_ack` are combinational. Flush responses show one cycle after the snoop. A miss completes in the cycle after its grant. The bench drives inputs on the falling edge and grants the bus from the `bus_req` it observes a moment later. It then compares every output against a behavioural model in the same cycle before the rising edge. Targeted checks measure request latency in cycles against the arbitration wait the bench chose, and read the flush one cycle after each snoop.

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_hit,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              evict_req,
  input  logic [IDX_W-1:0]  evict_idx,
  output logic              evict_ack,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_gnt,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_flush,
  output logic [DATA_W-1:0] snp_flush_data
);
  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam logic [1:0] ST_I = 2'd0, ST_S = 2'd1, ST_M = 2'd2;
  localparam logic [1:0] CMD_NONE = 2'd0, CMD_RD = 2'd1, CMD_RDX = 2'd2, CMD_WB = 2'd3;

  typedef enum logic [1:0] {PH_IDLE, PH_WB, PH_FILL} phase_t;

  logic [1:0]        st  [LINES];
  logic [TAG_W-1:0]  tg  [LINES];
  logic [DATA_W-1:0] dat [LINES];
  phase_t            ph;
  logic [IDX_W-1:0]  wb_idx;
  logic              missed;

  wire [IDX_W-1:0] c_idx = cpu_addr[IDX_W-1:0];
  wire [TAG_W-1:0] c_tag = cpu_addr[ADDR_W-1:IDX_W];
  wire [IDX_W-1:0] s_idx = snp_addr[IDX_W-1:0];
  wire [TAG_W-1:0] s_tag = snp_addr[ADDR_W-1:IDX_W];

  wire c_hit   = (st[c_idx] != ST_I) && (tg[c_idx] == c_tag);
  wire s_hit   = snp_valid && (st[s_idx] != ST_I) && (tg[s_idx] == s_tag);
  wire idle_go = (ph == PH_IDLE) && !snp_valid;
  wire ev_go   = idle_go && evict_req;
  wire cp_go   = idle_go && !evict_req && cpu_req;
  wire wb_live = (ph == PH_WB) && (st[wb_idx] == ST_M);

  assign evict_ack = ev_go && (st[evict_idx] != ST_M);
  assign cpu_ready = cp_go && c_hit && (!cpu_we || st[c_idx] == ST_M);
  assign cpu_hit   = cpu_ready && !missed;
  assign cpu_rdata = (cpu_ready && !cpu_we) ? dat[c_idx] : '0;

  assign bus_req   = !snp_valid && (wb_live || ph == PH_FILL);
  assign bus_cmd   = !bus_req ? CMD_NONE : (ph == PH_WB) ? CMD_WB : (cpu_we ? CMD_RDX : CMD_RD);
  assign bus_addr  = !bus_req ? '0 : (ph == PH_WB) ? {tg[wb_idx], wb_idx} : cpu_addr;
  assign bus_wdata = (bus_req && ph == PH_WB) ? dat[wb_idx] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph             <= PH_IDLE;
      wb_idx         <= '0;
      missed         <= 1'b0;
      snp_flush      <= 1'b0;
      snp_flush_data <= '0;
      for (int i = 0; i < LINES; i++) begin
        st[i]  <= ST_I;
        tg[i]  <= '0;
        dat[i] <= '0;
      end
    end else begin
      snp_flush <= 1'b0;
      if (snp_valid) begin
        if (s_hit && st[s_idx] == ST_M && (snp_cmd == CMD_RD || snp_cmd == CMD_RDX)) begin
          snp_flush      <= 1'b1;
          snp_flush_data <= dat[s_idx];
          st[s_idx]      <= (snp_cmd == CMD_RD) ? ST_S : ST_I;
        end else if (s_hit && st[s_idx] == ST_S && snp_cmd == CMD_RDX) begin
          st[s_idx] <= ST_I;
        end
      end else begin
        case (ph)
          PH_IDLE: begin
            if (evict_req) begin
              if (st[evict_idx] == ST_S) st[evict_idx] <= ST_I;
              else if (st[evict_idx] == ST_M) begin
                wb_idx <= evict_idx;
                ph     <= PH_WB;
              end
            end else if (cpu_req) begin
              if (cpu_ready) begin
                missed <= 1'b0;
                if (cpu_we) dat[c_idx] <= cpu_wdata;
              end else begin
                missed <= 1'b1;
                if (!c_hit && st[c_idx] == ST_M) begin
                  wb_idx <= c_idx;
                  ph     <= PH_WB;
                end else begin
                  ph <= PH_FILL;
                end
              end
            end
          end
          PH_WB: begin
            if (!wb_live) ph <= PH_IDLE;
            else if (bus_gnt) begin
              st[wb_idx] <= ST_I;
              ph         <= PH_IDLE;
            end
          end
          PH_FILL: begin
            if (bus_gnt) begin
              tg[c_idx]  <= c_tag;
              dat[c_idx] <= bus_rdata;
              st[c_idx]  <= cpu_we ? ST_M : ST_S;
              ph         <= PH_IDLE;
            end
          end
          default: ph <= PH_IDLE;
        endcase
      end
    end
  end

  AST_FILL_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt && bus_cmd == CMD_RD) |=> st[$past(c_idx)] == ST_S); // R2
  AST_FILL_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt && bus_cmd == CMD_RDX) |=> st[$past(c_idx)] == ST_M); // R3
  AST_HIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && cpu_hit) |-> !$past(bus_req)); // R4
  AST_FLUSH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    snp_flush |-> $past(snp_valid && snp_cmd != CMD_NONE)); // R5
  AST_RDX_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (s_hit && snp_cmd == CMD_RDX) |=> st[$past(s_idx)] == ST_I); // R6
  AST_WB_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt && bus_cmd == CMD_WB) |=> st[$past(wb_idx)] == ST_I); // R7
endmodule

// File: tb/tb_msi_snoop_ctrl.sv
module tb_msi_snoop_ctrl;
  localparam int AW = 8, DW = 16, IW = 2, NL = 4;

  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_we = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic cpu_ready, cpu_hit;
  logic [DW-1:0] cpu_rdata;
  logic evict_req = 0;
  logic [IW-1:0] evict_idx = '0;
  logic evict_ack;
  logic bus_req;
  logic [1:0] bus_cmd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic bus_gnt = 0;
  logic [DW-1:0] bus_rdata = '0;
  logic snp_valid = 0;
  logic [1:0] snp_cmd = '0;
  logic [AW-1:0] snp_addr = '0;
  logic snp_flush;
  logic [DW-1:0] snp_flush_data;

  msi_snoop_ctrl #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(IW)) dut (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  logic [DW-1:0] mem [256];
  int m_st[NL], m_tag[NL], m_dat[NL];
  int m_ph = 0, m_wb = 0, m_miss = 0, m_fl = 0, m_fd = 0;
  int cyc = 0, sn_at = -1, sn_cmd = 0, sn_addr = 0, prev_sn_addr = 0;
  int gwait = 0, gcnt = 0, wb_count = 0, flush_count = 0;
  bit obs_ready, obs_hit;
  int obs_rdata;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step();
    int ci, ct, si, stg, ev;
    bit sn, chit, shit, e_rdy, e_ack, e_req, e_hit;
    int e_cmd, e_addr, e_wd, e_rd;
    snp_valid = (cyc == sn_at);
    snp_cmd   = 2'(sn_cmd);
    snp_addr  = AW'(sn_addr);
    #1;
    bus_gnt   = bus_req && (gcnt >= gwait);
    bus_rdata = mem[bus_addr];
    #1;
    ci = int'(cpu_addr) % NL; ct = int'(cpu_addr) / NL;
    si = int'(snp_addr) % NL; stg = int'(snp_addr) / NL;
    ev = int'(evict_idx);
    sn = snp_valid;
    chit = (m_st[ci] != 0) && (m_tag[ci] == ct);
    shit = sn && (m_st[si] != 0) && (m_tag[si] == stg);
    e_rdy = 0; e_ack = 0; e_req = 0; e_cmd = 0; e_addr = 0; e_wd = 0;
    if (m_ph == 0 && !sn) begin
      if (evict_req) e_ack = (m_st[ev] != 2);
      else if (cpu_req) e_rdy = chit && (!cpu_we || m_st[ci] == 2);
    end
    if (!sn && m_ph == 1 && m_st[m_wb] == 2) begin
      e_req = 1; e_cmd = 3; e_addr = m_tag[m_wb] * NL + m_wb; e_wd = m_dat[m_wb];
    end
    if (!sn && m_ph == 2) begin
      e_req = 1; e_cmd = cpu_we ? 2 : 1; e_addr = int'(cpu_addr);
    end
    e_hit = e_rdy && (m_miss == 0);
    e_rd  = (e_rdy && !cpu_we) ? m_dat[ci] : 0;
    chk(cpu_ready == e_rdy, "R10 cpu_ready", cpu_ready, e_rdy);
    chk(cpu_hit == e_hit, "R4 cpu_hit", cpu_hit, e_hit);
    chk(int'(cpu_rdata) == e_rd, "R2 cpu_rdata", cpu_rdata, e_rd);
    chk(evict_ack == e_ack, "R7 evict_ack", evict_ack, e_ack);
    chk(bus_req == e_req, "R9 bus_req", bus_req, e_req);
    chk(int'(bus_cmd) == e_cmd, "R3 bus_cmd", bus_cmd, e_cmd);
    if (e_req) begin
      chk(int'(bus_addr) == e_addr, "R8 bus_addr", bus_addr, e_addr);
      chk(int'(bus_wdata) == e_wd, "R7 bus_wdata", bus_wdata, e_wd);
    end
    chk(snp_flush == m_fl[0], "R5 snp_flush", snp_flush, m_fl);
    if (m_fl != 0) chk(int'(snp_flush_data) == m_fd, "R5 snp_flush_data", snp_flush_data, m_fd);
    obs_ready = cpu_ready; obs_hit = cpu_hit; obs_rdata = int'(cpu_rdata);
    if (bus_gnt && bus_cmd == 2'd3) begin mem[bus_addr] = bus_wdata; wb_count++; end
    if (snp_flush) begin mem[prev_sn_addr] = snp_flush_data; flush_count++; end
    if (!bus_req) gcnt = 0; else if (bus_gnt) gcnt = 0; else gcnt++;
    // model next state
    m_fl = 0;
    if (sn) begin
      if (shit && m_st[si] == 2 && (sn_cmd == 1 || sn_cmd == 2)) begin
        m_fl = 1; m_fd = m_dat[si]; m_st[si] = (sn_cmd == 1) ? 1 : 0;
      end else if (shit && m_st[si] == 1 && sn_cmd == 2) m_st[si] = 0;
      prev_sn_addr = sn_addr;
    end else if (m_ph == 0) begin
      if (evict_req) begin
        if (m_st[ev] == 1) m_st[ev] = 0;
        else if (m_st[ev] == 2) begin m_wb = ev; m_ph = 1; end
      end else if (cpu_req) begin
        if (e_rdy) begin
          m_miss = 0;
          if (cpu_we) m_dat[ci] = int'(cpu_wdata);
        end else begin
          m_miss = 1;
          if (!chit && m_st[ci] == 2) begin m_wb = ci; m_ph = 1; end
          else m_ph = 2;
        end
      end
    end else if (m_ph == 1) begin
      if (m_st[m_wb] != 2) m_ph = 0;
      else if (bus_gnt) begin m_st[m_wb] = 0; m_ph = 0; end
    end else begin
      if (bus_gnt) begin
        m_tag[ci] = ct; m_dat[ci] = int'(bus_rdata); m_st[ci] = cpu_we ? 2 : 1; m_ph = 0;
      end
    end
    @(posedge clk);
    @(negedge clk);
    bus_gnt = 0; snp_valid = 0; cyc++;
  endtask

  task automatic cpu_op(bit we, int addr, int wd, output bit hit, output int rd, output int lat);
    cpu_req = 1; cpu_we = we; cpu_addr = AW'(addr); cpu_wdata = DW'(wd);
    lat = 0;
    for (int k = 0; k < 300; k++) begin
      step();
      if (obs_ready) break;
      lat++;
    end
    hit = obs_hit; rd = obs_rdata;
    cpu_req = 0; cpu_we = 0;
  endtask

  task automatic evict_op(int idx, output int lat);
    evict_req = 1; evict_idx = IW'(idx); lat = 0;
    for (int k = 0; k < 300; k++) begin
      #2;
      if (evict_ack) begin step(); break; end
      step();
      lat++;
    end
    evict_req = 0;
  endtask

  task automatic snoop_op(int cmd, int addr, output bit fl, output int fd);
    sn_at = cyc; sn_cmd = cmd; sn_addr = addr;
    step();
    fl = snp_flush; fd = int'(snp_flush_data);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  localparam int A = 8'h11, A2 = 8'h51, B = 8'h22, C = 8'h62, E = 8'h33;

  initial begin
    bit h, fl;
    int rd, lat, fd, wb0, fc0;
    for (int i = 0; i < 256; i++) mem[i] = DW'(i * 16'h0101) ^ 16'h1234;
    for (int i = 0; i < NL; i++) begin m_st[i] = 0; m_tag[i] = 0; m_dat[i] = 0; end
    repeat (3) @(negedge clk);
    chk(!cpu_ready && !bus_req && !snp_flush && !evict_ack, "R1 reset outputs", bus_req, 0);
    rst_n = 1;
    @(negedge clk);

    evict_op(1, lat);            chk(lat == 0, "R7 evict of invalid line", lat, 0);
    cpu_op(0, A, 0, h, rd, lat);
    chk(h == 0, "R1 first access misses", h, 0);
    chk(rd == int'(mem[A]), "R2 fill data", rd, mem[A]);
    chk(lat == 2, "R10 miss latency", lat, 2);
    cpu_op(0, A, 0, h, rd, lat); chk(h == 1 && lat == 0, "R4 read hit shared", lat, 0);
    cpu_op(1, A, 16'hBEEF, h, rd, lat); chk(h == 0 && lat == 2, "R3 write to shared", h, 0);
    cpu_op(1, A, 16'hC0DE, h, rd, lat); chk(h == 1 && lat == 0, "R4 write hit modified", h, 1);
    cpu_op(0, A, 0, h, rd, lat); chk(h == 1 && rd == 16'hC0DE, "R4 read hit modified", rd, 16'hC0DE);

    snoop_op(1, A, fl, fd);      chk(fl == 1 && fd == 16'hC0DE, "R5 flush on snooped read", fd, 16'hC0DE);
    cpu_op(0, A, 0, h, rd, lat); chk(h == 1, "R5 line left shared", h, 1);
    snoop_op(1, A, fl, fd);      chk(fl == 0, "R5 no flush from shared", fl, 0);
    cpu_op(1, A, 16'h1111, h, rd, lat); chk(h == 0, "R3 shared write needs ownership", h, 0);

    snoop_op(2, A, fl, fd);      chk(fl == 1 && fd == 16'h1111, "R6 flush on snooped ownership", fd, 16'h1111);
    cpu_op(0, A, 0, h, rd, lat); chk(h == 0 && rd == 16'h1111, "R6 modified line invalidated", rd, 16'h1111);
    snoop_op(2, A, fl, fd);      chk(fl == 0, "R6 shared invalidated silently", fl, 0);
    cpu_op(0, A, 0, h, rd, lat); chk(h == 0, "R6 shared line invalidated", h, 0);
    snoop_op(2, A2, fl, fd);     chk(fl == 0, "R6 other tag no flush", fl, 0);
    cpu_op(0, A, 0, h, rd, lat); chk(h == 1, "R6 other tag ignored", h, 1);

    evict_op(1, lat);            chk(lat == 0, "R7 silent shared eviction", lat, 0);
    cpu_op(0, A, 0, h, rd, lat); chk(h == 0, "R7 evicted line gone", h, 0);
    cpu_op(1, E, 16'h7777, h, rd, lat);
    wb0 = wb_count;
    evict_op(3, lat);
    chk(lat == 2, "R7 dirty eviction latency", lat, 2);
    chk(wb_count == wb0 + 1 && mem[E] == 16'h7777, "R7 dirty eviction written back", mem[E], 16'h7777);
    cpu_op(0, E, 0, h, rd, lat); chk(h == 0 && rd == 16'h7777, "R7 line refetched", rd, 16'h7777);

    cpu_op(1, B, 16'h2222, h, rd, lat);
    wb0 = wb_count;
    cpu_op(0, C, 0, h, rd, lat);
    chk(lat == 4 && h == 0, "R8 victim then fill latency", lat, 4);
    chk(wb_count == wb0 + 1 && mem[B] == 16'h2222, "R8 victim written back", mem[B], 16'h2222);
    cpu_op(0, B, 0, h, rd, lat); chk(h == 0 && rd == 16'h2222, "R8 victim data kept", rd, 16'h2222);

    sn_at = cyc; sn_cmd = 1; sn_addr = 8'h03;
    cpu_op(0, B, 0, h, rd, lat); chk(lat == 1 && h == 1, "R9 snoop delays hit", lat, 1);

    gwait = 5;
    cpu_op(0, C, 0, h, rd, lat); chk(lat == 7 && h == 0, "R10 stall for arbitration", lat, 7);
    gwait = 3;
    cpu_op(1, B, 16'h3333, h, rd, lat); chk(lat == 5 && h == 0, "R10 ownership stall", lat, 5);

    gwait = 6; wb0 = wb_count; fc0 = flush_count;
    sn_at = cyc + 3; sn_cmd = 2; sn_addr = B;
    cpu_op(0, C, 0, h, rd, lat);
    chk(wb_count == wb0, "R11 write-back dropped", wb_count, wb0);
    chk(flush_count == fc0 + 1 && mem[B] == 16'h3333, "R11 snoop flushed victim", mem[B], 16'h3333);
    chk(h == 0 && rd == int'(mem[C]), "R11 fetch completes", rd, mem[C]);

    repeat (2) step();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule